// File: doc/BRIEF.md
# Reset and Wake-up Cause Controller

This block sequences reset and sleep for a small 8-bit microcontroller core. It watches a power-good level, an asynchronous active-low external clear pin, a watchdog time-out pulse and a sleep request from the instruction decoder. From these it drives the core reset, a one-cycle wake-up pulse and a one-cycle watchdog clear. It also keeps a two-bit code that records what caused the last reset or wake.

When power comes up, the core stays in reset. The hold ends a fixed time after the synchronized clear pin is seen high, and that time is converted to clock cycles from a clock-frequency parameter. In normal running, a low clear pin holds the core in reset and a watchdog time-out gives a one-cycle reset. A sleep request parks the core and clears the watchdog, and the watchdog keeps counting while the core sleeps. Either a time-out or a low clear pin then wakes it. The block also presents the values that the program counter, the I/O direction register, the timer mode register, the indirect-address top bit and the upper status bits take on any reset.

Top module: `wake_reset_ctrl`

## Requirements
- R1: While powerGood is low, coreReset is 1. After powerGood is high, coreReset stays 1 until HOLD_CYCLES = CLK_HZ/1000*HOLD_MS cycles have passed in the hold phase. The hold phase starts once the synchronized clear pin is high, and a low synchronized pin during the hold restarts it. If the pin rises between edges c and c+1, coreReset first reads 0 after edge c+3+HOLD_CYCLES.
- R2: clearPinN is synchronized through two flops. A change of the pin between edges c and c+1 first affects the block's outputs after edge c+3.
- R3: A power-on reset (powerGood low) sets causeCode to 2'b11. Bit 1 of causeCode is the time-out flag (status bit 4) and bit 0 is the power-down flag (status bit 3).
- R4: A low clear pin while running holds coreReset at 1 as long as the synchronized pin is low and leaves causeCode unchanged. coreReset returns to 0 three edges after the pin rises.
- R5: A watchdog time-out while running gives coreReset = 1 for exactly one cycle after the next edge and sets causeCode to 2'b01.
- R6: A sleep request while running enters sleep. wdtClear is 1 for exactly one cycle after the next edge, and coreReset stays 0.
- R7: A watchdog time-out while asleep gives wakePulse = 1 for one cycle after the next edge and sets causeCode to 2'b00. coreReset stays 0 and the core returns to running.
- R8: A low synchronized clear pin while asleep gives wakePulse = 1 for one cycle, sets causeCode to 2'b10, and holds coreReset at 1 until the pin is high again.
- R9: When the synchronized clear pin is low and a time-out arrives at the same edge, the clear pin takes effect: in running causeCode stays unchanged, and in sleep it becomes 2'b10. During the power-on hold a time-out is ignored and causeCode stays 2'b11.
- R10: The reset-value outputs are always: pcInit all ones, dirInit all ones, tmodeInit with its low TMODE_ONES bits at 1 and the rest at 0 (8'h3F by default), fsrTopInit 1, statusHiInit 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| powerGood | input | 1 | High when supply is valid; low forces power-on reset asynchronously |
| clearPinN | input | 1 | Asynchronous active-low external clear pin |
| wdtTimeout | input | 1 | One-cycle watchdog time-out pulse |
| sleepReq | input | 1 | One-cycle sleep request from the instruction decoder |
| coreReset | output | 1 | Reset to the core, active high |
| wakePulse | output | 1 | One-cycle pulse on leaving sleep |
| wdtClear | output | 1 | One-cycle watchdog clear on sleep entry |
| causeCode | output | 2 | {time-out flag, power-down flag} |
| pcInit | output | PC_W | Program counter reset value |
| dirInit | output | DIR_W | I/O direction register reset value |
| tmodeInit | output | TMODE_W | Timer mode register reset value |
| fsrTopInit | output | 1 | Reset value of indirect-address bit 7 |
| statusHiInit | output | 3 | Reset value of status bits 7 to 5 |

## Verification
A wrong sequencer state first shows on coreReset. If the block stalls in a reset state, the reset does not fall three edges after the pin rises. If it wrongly leaves a reset state, the reset falls early, one hold period or one cycle too soon. A flag update that goes to the wrong branch appears on causeCode in the cycle right after the triggering edge, and it stays visible until the next event. A wake taken from the wrong state shows as a wakePulse that is missing or extra in that same cycle. A miscount of the synchronizer or the hold counter moves the release edge by whole cycles, so the release is checked one cycle before and at the expected edge.

// File: rtl/wrc_pkg.sv
package wrc_pkg;

  typedef enum logic [2:0] {
    ST_POR_WAIT = 3'd0,
    ST_POR_HOLD = 3'd1,
    ST_RUN      = 3'd2,
    ST_SLEEP    = 3'd3,
    ST_PIN_HOLD = 3'd4,
    ST_WDT_RST  = 3'd5
  } wrcState_e;

  // strobes from control to datapath, registered there
  typedef struct packed {
    logic holdCount;
    logic loadPinSleep;
    logic loadWdtRun;
    logic loadWdtSleep;
    logic wdtClr;
    logic wake;
  } wrcStrobe_t;

  // {time-out flag, power-down flag}
  localparam logic [1:0] CAUSE_POWERON   = 2'b11;
  localparam logic [1:0] CAUSE_PIN_SLEEP = 2'b10;
  localparam logic [1:0] CAUSE_WDT_RUN   = 2'b01;
  localparam logic [1:0] CAUSE_WDT_SLEEP = 2'b00;

endpackage

// File: rtl/wrc_sync.sv
module wrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic powerGood,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge powerGood) begin
          if (!powerGood) chain[0] <= 1'b0;
          else            chain[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge powerGood) begin
          if (!powerGood) chain[i] <= 1'b0;
          else            chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/wrc_ctrl.sv
module wrc_ctrl
  import wrc_pkg::*;
(
  input  logic       clk,
  input  logic       powerGood,
  input  logic       pinHigh,
  input  logic       wdtTimeout,
  input  logic       sleepReq,
  input  logic       holdDone,
  output wrcStrobe_t strobe,
  output logic       coreReset
);
  wrcState_e state, nextState;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) state <= ST_POR_WAIT;
    else            state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_POR_WAIT: begin
        if (pinHigh) nextState = ST_POR_HOLD;
      end
      ST_POR_HOLD: begin
        if (!pinHigh) begin
          nextState = ST_POR_WAIT;
        end else begin
          strobe.holdCount = 1'b1;
          if (holdDone) nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!pinHigh) begin
          nextState = ST_PIN_HOLD;
        end else if (wdtTimeout) begin
          nextState         = ST_WDT_RST;
          strobe.loadWdtRun = 1'b1;
        end else if (sleepReq) begin
          nextState     = ST_SLEEP;
          strobe.wdtClr = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!pinHigh) begin
          nextState           = ST_PIN_HOLD;
          strobe.loadPinSleep = 1'b1;
          strobe.wake         = 1'b1;
        end else if (wdtTimeout) begin
          nextState           = ST_RUN;
          strobe.loadWdtSleep = 1'b1;
          strobe.wake         = 1'b1;
        end
      end
      ST_PIN_HOLD: begin
        if (pinHigh) nextState = ST_RUN;
      end
      ST_WDT_RST: begin
        nextState = pinHigh ? ST_RUN : ST_PIN_HOLD;
      end
      default: nextState = ST_POR_WAIT;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_RUN, ST_SLEEP: coreReset = 1'b0;
      default:          coreReset = 1'b1;
    endcase
  end
endmodule

// File: rtl/wrc_datapath.sv
module wrc_datapath
  import wrc_pkg::*;
#(
  parameter int HOLD_CYCLES = 36,
  parameter int PC_W        = 8,
  parameter int DIR_W       = 8,
  parameter int TMODE_W     = 8,
  parameter int TMODE_ONES  = 6,
  parameter int STATUS_HI_W = 3
) (
  input  logic                   clk,
  input  logic                   powerGood,
  input  wrcStrobe_t             strobe,
  output logic                   holdDone,
  output logic                   wakePulse,
  output logic                   wdtClear,
  output logic [1:0]             causeCode,
  output logic [PC_W-1:0]        pcInit,
  output logic [DIR_W-1:0]       dirInit,
  output logic [TMODE_W-1:0]     tmodeInit,
  output logic                   fsrTopInit,
  output logic [STATUS_HI_W-1:0] statusHiInit
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood)           holdCnt <= '0;
    else if (strobe.holdCount) holdCnt <= holdCnt + 1'b1;
    else                       holdCnt <= '0;
  end

  assign holdDone = (holdCnt == CNT_LAST);

  always_ff @(posedge clk or negedge powerGood) begin
    if (!powerGood) begin
      causeCode <= CAUSE_POWERON;
      wakePulse <= 1'b0;
      wdtClear  <= 1'b0;
    end else begin
      wakePulse <= strobe.wake;
      wdtClear  <= strobe.wdtClr;
      if (strobe.loadPinSleep)      causeCode <= CAUSE_PIN_SLEEP;
      else if (strobe.loadWdtRun)   causeCode <= CAUSE_WDT_RUN;
      else if (strobe.loadWdtSleep) causeCode <= CAUSE_WDT_SLEEP;
    end
  end

  assign pcInit       = '1;
  assign dirInit      = '1;
  assign fsrTopInit   = 1'b1;
  assign statusHiInit = '0;

  generate
    for (genvar b = 0; b < TMODE_W; b++) begin : gTmode
      if (b < TMODE_ONES) begin : gOne
        assign tmodeInit[b] = 1'b1;
      end else begin : gZero
        assign tmodeInit[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/wake_reset_ctrl.sv
module wake_reset_ctrl
  import wrc_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int HOLD_MS     = 18,
  parameter int SYNC_STAGES = 2,
  parameter int PC_W        = 8,
  parameter int DIR_W       = 8,
  parameter int TMODE_W     = 8,
  parameter int TMODE_ONES  = 6
) (
  input  logic               clk,
  input  logic               powerGood,
  input  logic               clearPinN,
  input  logic               wdtTimeout,
  input  logic               sleepReq,
  output logic               coreReset,
  output logic               wakePulse,
  output logic               wdtClear,
  output logic [1:0]         causeCode,
  output logic [PC_W-1:0]    pcInit,
  output logic [DIR_W-1:0]   dirInit,
  output logic [TMODE_W-1:0] tmodeInit,
  output logic               fsrTopInit,
  output logic [2:0]         statusHiInit
);
  localparam int HOLD_CYCLES = (CLK_HZ / 1000) * HOLD_MS;

  logic       pinHigh;
  logic       holdDone;
  wrcStrobe_t strobe;

  wrc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .powerGood(powerGood), .asyncIn(clearPinN), .syncOut(pinHigh)
  );

  wrc_ctrl uCtrl (
    .clk(clk), .powerGood(powerGood), .pinHigh(pinHigh),
    .wdtTimeout(wdtTimeout), .sleepReq(sleepReq), .holdDone(holdDone),
    .strobe(strobe), .coreReset(coreReset)
  );

  wrc_datapath #(
    .HOLD_CYCLES(HOLD_CYCLES), .PC_W(PC_W), .DIR_W(DIR_W),
    .TMODE_W(TMODE_W), .TMODE_ONES(TMODE_ONES), .STATUS_HI_W(3)
  ) uData (
    .clk(clk), .powerGood(powerGood), .strobe(strobe), .holdDone(holdDone),
    .wakePulse(wakePulse), .wdtClear(wdtClear), .causeCode(causeCode),
    .pcInit(pcInit), .dirInit(dirInit), .tmodeInit(tmodeInit),
    .fsrTopInit(fsrTopInit), .statusHiInit(statusHiInit)
  );
endmodule

// File: rtl/wake_reset_ctrl_chk.sv
module wake_reset_ctrl_chk (
  input logic       clk,
  input logic       powerGood,
  input logic       clearPinN,
  input logic       coreReset,
  input logic       wakePulse,
  input logic       wdtClear,
  input logic [1:0] causeCode
);
  assert_wdtclr_single_R6: assert property (@(posedge clk) disable iff (!powerGood)
    wdtClear |=> !wdtClear);

  assert_sleep_no_reset_R6: assert property (@(posedge clk) disable iff (!powerGood)
    wdtClear |-> !coreReset);

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!powerGood)
    wakePulse |=> !wakePulse);

  assert_wdt_wake_code_R7: assert property (@(posedge clk) disable iff (!powerGood)
    (wakePulse && !coreReset) |-> (causeCode == 2'b00));

  assert_cause_hold_R4: assert property (@(posedge clk) disable iff (!powerGood)
    !$stable(causeCode) |-> (coreReset || wakePulse));

  assert_release_pin_high_R2: assert property (@(posedge clk) disable iff (!powerGood)
    $fell(coreReset) |-> $past(clearPinN, 2));
endmodule

bind wake_reset_ctrl wake_reset_ctrl_chk uChk (
  .clk(clk), .powerGood(powerGood), .clearPinN(clearPinN),
  .coreReset(coreReset), .wakePulse(wakePulse), .wdtClear(wdtClear),
  .causeCode(causeCode)
);

// File: tb/wake_reset_ctrl_test.sv
module wake_reset_ctrl_test;
  localparam int HOLD = 36;  // 2000 Hz * 18 ms / 1000

  logic clk = 1'b0;
  logic powerGood = 1'b0, clearPinN = 1'b0, wdtTimeout = 1'b0, sleepReq = 1'b0;
  logic coreReset, wakePulse, wdtClear, fsrTopInit;
  logic [1:0] causeCode;
  logic [7:0] pcInit, dirInit, tmodeInit;
  logic [2:0] statusHiInit;

  always #2.5 clk = ~clk;

  wake_reset_ctrl #(.CLK_HZ(2000), .HOLD_MS(18)) uut (
    .clk(clk), .powerGood(powerGood), .clearPinN(clearPinN),
    .wdtTimeout(wdtTimeout), .sleepReq(sleepReq), .coreReset(coreReset),
    .wakePulse(wakePulse), .wdtClear(wdtClear), .causeCode(causeCode),
    .pcInit(pcInit), .dirInit(dirInit), .tmodeInit(tmodeInit),
    .fsrTopInit(fsrTopInit), .statusHiInit(statusHiInit)
  );

  typedef struct {
    int    cyc;
    int    what;
    int    exp;
    string req;
  } item_t;

  item_t q[$];
  int cyc = 0, compared = 0, mismatched = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int probe(int w);
    case (w)
      0: return int'(coreReset);
      1: return int'(causeCode);
      2: return int'(wakePulse);
      3: return int'(wdtClear);
      4: return int'(pcInit);
      5: return int'(dirInit);
      6: return int'(tmodeInit);
      7: return int'(fsrTopInit);
      default: return int'(statusHiInit);
    endcase
  endfunction

  // driver side: queue an expectation k edges from now
  task automatic expect_in(int k, int w, int v, string req);
    item_t it;
    it.cyc = cyc + k; it.what = w; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wdt();
    wdtTimeout = 1'b1; tick(1); wdtTimeout = 1'b0;
  endtask

  task automatic pulse_sleep();
    sleepReq = 1'b1; tick(1); sleepReq = 1'b0;
  endtask

  // monitor: compare queued items at their cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = probe(it.what);
      compared++;
      if (act != it.exp) begin
        mismatched++;
        $display("FAIL %s sig%0d actual=%0d expected=%0d at cycle %0d",
                 it.req, it.what, act, it.exp, cyc);
      end
    end
  end

  initial begin
    tick(3);
    // R1 R3 R10: in power-on reset
    expect_in(1, 0, 1, "R1");
    expect_in(1, 1, 3, "R3");
    expect_in(1, 4, 255, "R10");
    expect_in(1, 5, 255, "R10");
    expect_in(1, 6, 8'h3F, "R10");
    expect_in(1, 7, 1, "R10");
    expect_in(1, 8, 0, "R10");
    tick(2);
    powerGood = 1'b1;
    expect_in(6, 0, 1, "R1");
    tick(8);
    // pin rises, drops for one cycle (restart), rises again
    clearPinN = 1'b1; tick(10);
    clearPinN = 1'b0; tick(1);
    clearPinN = 1'b1;
    expect_in(3 + HOLD - 1, 0, 1, "R1");
    expect_in(3 + HOLD, 0, 0, "R1");
    expect_in(3 + HOLD, 1, 3, "R3");
    tick(20);
    pulse_wdt();                       // R9: ignored during power-on hold
    expect_in(2, 1, 3, "R9");
    tick(30);
    // R5: watchdog while running
    expect_in(1, 0, 1, "R5");
    expect_in(1, 1, 1, "R5");
    expect_in(2, 0, 0, "R5");
    pulse_wdt(); tick(4);
    // R6: sleep entry
    expect_in(1, 3, 1, "R6");
    expect_in(1, 0, 0, "R6");
    expect_in(2, 3, 0, "R6");
    pulse_sleep(); tick(4);
    // R7: watchdog wake
    expect_in(1, 2, 1, "R7");
    expect_in(1, 0, 0, "R7");
    expect_in(1, 1, 0, "R7");
    expect_in(2, 2, 0, "R7");
    pulse_wdt(); tick(4);
    // R8 R2: pin wake from sleep
    pulse_sleep(); tick(3);
    clearPinN = 1'b0;
    expect_in(2, 0, 0, "R2");
    expect_in(3, 0, 1, "R8");
    expect_in(3, 2, 1, "R8");
    expect_in(3, 1, 2, "R8");
    expect_in(4, 2, 0, "R8");
    tick(5);
    clearPinN = 1'b1;
    expect_in(2, 0, 1, "R8");
    expect_in(3, 0, 0, "R8");
    tick(6);
    // R4: pin reset while running, cause 2 kept
    clearPinN = 1'b0;
    expect_in(3, 0, 1, "R4");
    expect_in(3, 1, 2, "R4");
    tick(6);
    clearPinN = 1'b1;
    expect_in(2, 0, 1, "R4");
    expect_in(3, 0, 0, "R4");
    tick(6);
    pulse_wdt(); tick(4);              // cause now 1
    clearPinN = 1'b0;
    expect_in(4, 1, 1, "R4");
    tick(6); clearPinN = 1'b1; tick(6);
    // R9: pin and watchdog at the same edge while running
    clearPinN = 1'b0;
    expect_in(3, 0, 1, "R9");
    expect_in(3, 1, 1, "R9");
    expect_in(4, 0, 1, "R9");
    tick(2); pulse_wdt(); tick(4);
    clearPinN = 1'b1; tick(6);
    // R9: same collision while asleep
    pulse_sleep(); tick(3);
    clearPinN = 1'b0;
    expect_in(3, 1, 2, "R9");
    expect_in(3, 2, 1, "R9");
    expect_in(3, 0, 1, "R9");
    tick(2); pulse_wdt(); tick(4);
    clearPinN = 1'b1; tick(6);
    // R3: power loss again from cause 2
    powerGood = 1'b0;
    expect_in(1, 1, 3, "R3");
    expect_in(1, 0, 1, "R1");
    tick(4);
    wait (q.size() == 0);
    tick(1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule